// File: doc/BRIEF.md
# Error-Correcting Two-Port Word Store

This block is a RAM with one write port and one read port, both on the same clock. It protects every stored word with a single-error-correct, double-error-detect code. On the write side, each data word gets extra check bits and one overall parity bit. The widened codeword is then written to storage in a single cycle. On the read side, the stored codeword is registered out of the array, checked and repaired. The corrected data leaves the block together with a two-bit status and a valid strobe, and all three are aligned to the same cycle.

Writes always cover the whole word. There are no byte enables, and both ports use the same width. The write port carries a fault-injection control. It can flip one codeword bit, or two adjacent codeword bits, at a position the caller selects. A damaged word can therefore be stored on purpose, and the repair or detection path can be checked when that word is read back. A corrected word is only repaired at the output; the copy in the array is never rewritten.

Top module: `ecc_sdp_ram`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rd_valid` is 0, `rd_status` is 00 and `rd_data` is zero.
- R2: The stored codeword is DATA_W + C + 1 bits wide. C is the smallest count with 2^C >= DATA_W + C + 1. Codeword bits [DATA_W-1:0] hold the data bits unchanged. The C check bits sit above them, and the overall parity bit is the top bit.
- R3: A read accepted at a clock edge presents `rd_valid`=1 with its data and status exactly 1 + DEC_PIPE cycles later. A new read may be accepted on every cycle.
- R4: A word written with `wr_err_mode`=00 reads back unchanged, with `rd_status`=00 (no error).
- R5: `wr_err_mode`=11 is reserved and has the same effect as 00: the word reads back unchanged with status 00.
- R6: With `wr_err_mode`=01, codeword bit `wr_err_pos` is inverted before storage. The read returns the original data with `rd_status`=01 (corrected), for every position from 0 to DATA_W + C.
- R7: With `wr_err_mode`=10, codeword bits `wr_err_pos` and the next one up are inverted; the next one up wraps from the top bit to bit 0. The read returns `rd_status`=10 (double error). The data is passed through uncorrected, so any inverted bit below DATA_W appears inverted in `rd_data`.
- R8: When a read and a write target the same address in the same cycle, the read returns the word stored before that write. A later read returns the new word.
- R9: Whenever `rd_valid` is 0, `rd_data` is zero and `rd_status` is 00.
- R10: `rd_status` never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_err_mode | input | 2 | Fault injection: 00 none, 01 one bit, 10 two bits, 11 reserved (none) |
| wr_err_pos | input | clog2(DATA_W+C+1) | Codeword index of the first inverted bit |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read result qualifier |
| rd_data | output | DATA_W | Corrected read data |
| rd_status | output | 2 | 00 clean, 01 corrected, 10 double error |

## Verification
The properties assume that `rd_en` is never unknown once reset is released. They also assume that `wr_err_pos` stays below the codeword width whenever injection is requested. The stimulus changes every input only on the falling clock edge and sweeps injection positions only from 0 to the top codeword bit. Every word is written before it is first read, so the array is never read while uninitialised.

// File: rtl/ecc_sdp_pkg.sv
package ecc_sdp_pkg;

    typedef enum logic [1:0] {
        STAT_CLEAN  = 2'b00,
        STAT_FIXED  = 2'b01,
        STAT_DOUBLE = 2'b10
    } rd_stat_e;

    typedef enum logic [1:0] {
        INJ_NONE = 2'b00,
        INJ_ONE  = 2'b01,
        INJ_TWO  = 2'b10,
        INJ_RSVD = 2'b11
    } inj_mode_e;

    // Smallest check-bit count that can name every codeword slot
    function automatic int chk_count(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    // Hamming slot (1-based, never a power of two) of data bit idx
    function automatic int data_slot(input int idx);
        int p;
        int seen;
        p = 0;
        seen = -1;
        while (seen < idx) begin
            p++;
            if ((p & (p - 1)) != 0) seen++;
        end
        return p;
    endfunction

endpackage

// File: rtl/ecc_chk_gen.sv
module ecc_chk_gen #(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);
    logic [CHK_W-1:0] term [DATA_W];

    for (genvar i = 0; i < DATA_W; i++) begin : g_term
        localparam logic [CHK_W-1:0] SLOT_V = CHK_W'(ecc_sdp_pkg::data_slot(i));
        assign term[i] = data_i[i] ? SLOT_V : '0;
    end

    always_comb begin
        chk_o = '0;
        for (int i = 0; i < DATA_W; i++) chk_o ^= term[i];
    end
endmodule

// File: rtl/ecc_enc.sv
module ecc_enc
    import ecc_sdp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4,
    parameter int CODE_W = DATA_W + CHK_W + 1,
    parameter int POS_W  = $clog2(CODE_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [1:0]        mode_i,
    input  logic [POS_W-1:0]  pos_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CHK_W-1:0]  chk;
    logic [CODE_W-2:0] base;
    logic [CODE_W-1:0] mask_one, mask_two, flip;
    logic [POS_W-1:0]  nxt;

    ecc_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
        .data_i(data_i),
        .chk_o (chk)
    );

    assign base = {chk, data_i};
    assign nxt  = (32'(pos_i) == CODE_W - 1) ? '0 : pos_i + 1'b1;

    always_comb begin
        mask_one = '0;
        mask_two = '0;
        if (32'(pos_i) < CODE_W) begin
            mask_one[pos_i] = 1'b1;
            mask_two        = mask_one;
            mask_two[nxt]   = 1'b1;
        end
    end

    always_comb begin
        unique case (inj_mode_e'(mode_i))
            INJ_ONE:  flip = mask_one;
            INJ_TWO:  flip = mask_two;
            INJ_NONE: flip = '0;
            INJ_RSVD: flip = '0;
        endcase
    end

    assign code_o = {^base, base} ^ flip;
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_sdp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4,
    parameter int CODE_W = DATA_W + CHK_W + 1
) (
    input  logic              vld_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic [1:0]        stat_o
);
    logic [DATA_W-1:0] data_rx, flip_bit;
    logic [CHK_W-1:0]  chk_calc, syn;
    logic              par_err;
    rd_stat_e          stat;

    assign data_rx = code_i[DATA_W-1:0];

    ecc_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
        .data_i(data_rx),
        .chk_o (chk_calc)
    );

    assign syn     = chk_calc ^ code_i[DATA_W +: CHK_W];
    assign par_err = ^code_i;

    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        localparam logic [CHK_W-1:0] SLOT_V = CHK_W'(data_slot(i));
        assign flip_bit[i] = par_err && (syn == SLOT_V);
    end

    always_comb begin
        if (!vld_i)           stat = STAT_CLEAN;
        else if (par_err)     stat = STAT_FIXED;
        else if (syn != '0)   stat = STAT_DOUBLE;
        else                  stat = STAT_CLEAN;
    end

    assign stat_o = stat;
    assign data_o = vld_i ? (data_rx ^ flip_bit) : '0;
endmodule

// File: rtl/ecc_store.sv
module ecc_store #(
    parameter int WORD_W = 13,
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word_o,
    output logic              rd_vld_o
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_word;
        if (rd_en) rd_word_o    <= mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_vld_o <= 1'b0;
        else        rd_vld_o <= rd_en;
    end
endmodule

// File: rtl/ecc_sdp_ram.sv
module ecc_sdp_ram
    import ecc_sdp_pkg::*;
#(
    parameter  int DATA_W   = 8,
    parameter  int ADDR_W   = 4,
    parameter  int DEC_PIPE = 1,
    localparam int CHK_W    = chk_count(DATA_W),
    localparam int CODE_W   = DATA_W + CHK_W + 1,
    localparam int POS_W    = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        wr_err_mode,
    input  logic [POS_W-1:0]  wr_err_pos,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_status
);
    logic [CODE_W-1:0] wr_code, rd_code;
    logic              mem_vld;
    logic [DATA_W-1:0] dec_data;
    logic [1:0]        dec_stat;

    ecc_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W), .POS_W(POS_W)) u_enc (
        .data_i(wr_data),
        .mode_i(wr_err_mode),
        .pos_i (wr_err_pos),
        .code_o(wr_code)
    );

    ecc_store #(.WORD_W(CODE_W), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_word  (wr_code),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_word_o(rd_code),
        .rd_vld_o (mem_vld)
    );

    ecc_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_dec (
        .vld_i (mem_vld),
        .code_i(rd_code),
        .data_o(dec_data),
        .stat_o(dec_stat)
    );

    if (DEC_PIPE != 0) begin : g_pipe
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_valid  <= 1'b0;
                rd_data   <= '0;
                rd_status <= STAT_CLEAN;
            end else begin
                rd_valid  <= mem_vld;
                rd_data   <= dec_data;
                rd_status <= dec_stat;
            end
        end
    end else begin : g_flow
        assign rd_valid  = mem_vld;
        assign rd_data   = dec_data;
        assign rd_status = dec_stat;
    end
endmodule

// File: rtl/ecc_sdp_ram_chk.sv
module ecc_sdp_ram_chk #(
    parameter int DATA_W   = 8,
    parameter int DEC_PIPE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        rd_status
);
    localparam int LAT = 1 + DEC_PIPE;

    // R3
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ##LAT rd_valid);

    // R3
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> ##LAT !rd_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_status == 2'b00) && (rd_data == '0));

    // R10
    legal_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status != 2'b11);

    // R1
    reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rd_valid);
endmodule

bind ecc_sdp_ram ecc_sdp_ram_chk #(.DATA_W(DATA_W), .DEC_PIPE(DEC_PIPE)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_status(rd_status)
);

// File: tb/ecc_sdp_ram_tb_top.sv
module ecc_sdp_ram_tb_top;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int DEC_PIPE = 1;
    localparam int LAT      = 1 + DEC_PIPE;
    localparam int CHK_W    = 4;
    localparam int CODE_W   = DATA_W + CHK_W + 1;
    localparam int POS_W    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0]        wr_err_mode = 2'b00;
    logic [POS_W-1:0]  wr_err_pos = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [1:0]        rd_status;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ecc_sdp_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEC_PIPE(DEC_PIPE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_err_mode(wr_err_mode), .wr_err_pos(wr_err_pos),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_status(rd_status)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic do_write(input int a, input int d, input int m, input int p);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
        wr_err_mode = 2'(m); wr_err_pos = POS_W'(p);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_err_mode = 2'b00;
    endtask

    task automatic do_read(input int a, output int d, output int s, output int v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = ADDR_W'(a);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        for (int k = 1; k < LAT; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        d = int'(rd_data); s = int'(rd_status); v = int'(rd_valid);
    endtask

    function automatic int two_flip(input int d, input int p);
        int m, q;
        m = d;
        q = (p == CODE_W - 1) ? 0 : p + 1;
        if (p < DATA_W) m = m ^ (1 << p);
        if (q < DATA_W) m = m ^ (1 << q);
        return m;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int d, s, v, ed;
        // R1: during and just after reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid in reset", int'(rd_valid), 0);
        check("R1 status in reset", int'(rd_status), 0);
        check("R1 data in reset", int'(rd_data), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 valid after reset", int'(rd_valid), 0);

        // R4 / R5: every data value, clean or reserved inject mode
        for (int x = 0; x < 256; x++) begin
            int md;
            md = (x % 8 == 7) ? 3 : 0;
            do_write(x % 16, x, md, x % CODE_W);
            do_read(x % 16, d, s, v);
            check(md == 3 ? "R5 data" : "R4 data", d, x);
            check(md == 3 ? "R5 status" : "R4 status", s, 0);
            check("R3 valid", v, 1);
        end

        // R6 / R7 / R2: every codeword position, one and two bit faults
        for (int p = 0; p < CODE_W; p++) begin
            for (int k = 0; k < 8; k++) begin
                int x;
                x = (k * 37 + 5 + p) & 255;
                do_write(k, x, 1, p);
                do_read(k, d, s, v);
                check("R6 data", d, x);
                check("R6 status", s, 1);
                do_write(k + 8, x, 2, p);
                do_read(k + 8, d, s, v);
                ed = two_flip(x, p);
                check("R7 R2 data", d, ed);
                check("R7 status", s, 2);
            end
        end

        // R8: same-cycle read and write of one address
        do_write(5, 8'hA5, 0, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd5; wr_data = 8'h5A;
        rd_en = 1'b1; rd_addr = 4'd5;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        for (int k = 1; k < LAT; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        check("R8 old word", int'(rd_data), 8'hA5);
        do_read(5, d, s, v);
        check("R8 new word", d, 8'h5A);

        // R3: back-to-back reads, one per cycle
        for (int a = 0; a < 16; a++) do_write(a, (a * 17 + 3) & 255, 0, 0);
        for (int c = 0; c < 16 + LAT; c++) begin
            @(negedge clk);
            if (c >= LAT) begin
                check("R3 stream valid", int'(rd_valid), 1);
                check("R3 stream data", int'(rd_data), ((c - LAT) * 17 + 3) & 255);
            end
            rd_en = (c < 16);
            rd_addr = ADDR_W'(c);
            @(posedge clk);
        end
        rd_en = 1'b0;

        // R9 / R10: idle outputs
        repeat (LAT + 1) @(posedge clk);
        @(negedge clk);
        check("R9 valid idle", int'(rd_valid), 0);
        check("R9 data idle", int'(rd_data), 0);
        check("R10 status idle", int'(rd_status), 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule